// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is the clock/calendar corner of a byte-wide memory-mapped register space. It owns eight byte registers that hold seconds, minutes, hours in 24-hour form, day of the week, date, month, year and century, all in packed BCD. A one-second tick arrives as a clock-enable pulse. On each tick an internal counter set advances, with carries through the calendar and with the days of each month and leap years handled.

Software never touches the internal counters directly. Every bus access goes to an external copy. While both control bits are clear, the external copy is refreshed from the internal counters on every tick. Setting the read bit freezes the external copy, so that a multi-byte read stays coherent while the internal counters keep running. Setting the write bit also freezes it. Software then writes a new time into the external copy, and clearing the write bit loads that time into the internal counters. A stop bit in the seconds register halts timekeeping altogether.

Top module: `bcd_clock_regs`

## Requirements
- R1: After reset the registers read, by offset 0 to 7: 0x80, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00, 0x20. That is: stopped at second 00, minute 00, hour 00, day 01, date 01, month 01, year 00, century 20, with both control bits clear.
- R2: On each tick while running, seconds advance in BCD and wrap 59 to 00 with a carry into minutes. Minutes do the same into hours. Hours wrap 23 to 00 with a carry into day of week and date. Day of week wraps 07 to 01.
- R3: The date wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11; 29 for month 02 when the year is a multiple of 4, otherwise 28; 31 for all other months. The wrap carries into the month. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century. Century 39 wraps to 00.
- R4: The internal counters advance on every tick while running, whatever the control bits hold.
- R5: While the read bit (bit 6 of offset 7) is 1, the external copy at offsets 0 to 6 does not change on ticks. Its century field does not change on ticks either.
- R6: Once both control bits are 0, the external copy is refreshed only by a tick that arrives more than MIN_LOW_CYC clock cycles after the write that cleared them. The refresh shows the internal count after that tick.
- R7: When a write to offset 7 clears the write bit (bit 7) while it is 1, the internal counters are loaded from the external copy, with the century taken from the bits 5:0 just written. While the write bit is 1, writes to the time registers reach only the external copy.
- R8: A bus write always lands in the addressed external register at once. When both control bits are 0, a written time field is replaced at the next refresh, and the internal counters are left unchanged.
- R9: Bit 7 of the seconds register stops timekeeping while it is 1: ticks then change neither the internal nor the external registers.
- R10: Bits outside the time fields read back as last written and survive refreshes. The time fields are: seconds and minutes bits 6:0, hours and date bits 5:0, day bits 2:0, month bits 4:0, year bits 7:0, century bits 5:0. This includes the frequency-test bit (bit 6 of offset 3), which resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second clock-enable pulse |
| we_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | 3 | Register offset: 0 sec, 1 min, 2 hour, 3 day, 4 date, 5 month, 6 year, 7 control/century |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Read data of the addressed external register |

## Verification
The hardest situation to reach is a tick that lands after the read bit has dropped but before the resume interval has run out. That tick must advance the internal count yet leave the stale external copy in place. The bench clears the read bit, idles a handful of cycles, ticks, and then checks that the registers are still frozen. It then idles well past the interval and ticks again, expecting every second counted during the freeze to appear at once. Calendar carries are reached by loading times one second before a boundary through the write-bit sequence. Random loads are weighted towards 23:59:59 and month ends so that multi-field carries occur often.

// File: rtl/bcd_clk_pkg.sv
`timescale 1ns/1ps
package bcd_clk_pkg;
  localparam int NREG = 8;
  localparam int DW   = 8;
  localparam int AW   = $clog2(NREG);

  typedef logic [NREG-1:0][DW-1:0] bank_t;

  // member order puts seconds in the lowest byte, matching bank index 0
  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } time_t;

  localparam logic [AW-1:0] IDX_SEC  = AW'(0);
  localparam logic [AW-1:0] IDX_CTRL = AW'(7);

  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      0, 1:    field_mask = 8'h7F;
      2, 4:    field_mask = 8'h3F;
      3:       field_mask = 8'h07;
      5:       field_mask = 8'h1F;
      6:       field_mask = 8'hFF;
      default: field_mask = 8'h3F;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) is_leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       is_leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      last_date = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  endfunction

  function automatic bank_t reset_bank();
    bank_t b;
    b = '0;
    b[0] = 8'h80;
    b[3] = 8'h01;
    b[4] = 8'h01;
    b[5] = 8'h01;
    b[7] = 8'h20;
    return b;
  endfunction
endpackage

// File: rtl/bcd_time_core.sv
`timescale 1ns/1ps
module bcd_time_core
  import bcd_clk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  run_i,
  input  logic  load_i,
  input  time_t load_val_i,
  output time_t cur_o,
  output time_t nxt_o
);
  time_t cur_q, cur_d, inc;
  logic  c_min, c_hour, c_day, c_mon, c_year, c_cent;

  // value the counters take after one second
  always_comb begin
    inc    = cur_q;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    c_cent = 1'b0;
    if (cur_q.sec >= 8'h59) begin inc.sec = 8'h00; c_min = 1'b1; end
    else                          inc.sec = bcd_inc(cur_q.sec);
    if (c_min) begin
      if (cur_q.min >= 8'h59) begin inc.min = 8'h00; c_hour = 1'b1; end
      else                          inc.min = bcd_inc(cur_q.min);
    end
    if (c_hour) begin
      if (cur_q.hour >= 8'h23) begin inc.hour = 8'h00; c_day = 1'b1; end
      else                           inc.hour = bcd_inc(cur_q.hour);
    end
    if (c_day) begin
      inc.day = (cur_q.day >= 8'h07) ? 8'h01 : bcd_inc(cur_q.day);
      if (cur_q.date >= last_date(cur_q.mon, cur_q.year)) begin
        inc.date = 8'h01;
        c_mon    = 1'b1;
      end else begin
        inc.date = bcd_inc(cur_q.date);
      end
    end
    if (c_mon) begin
      if (cur_q.mon >= 8'h12) begin inc.mon = 8'h01; c_year = 1'b1; end
      else                          inc.mon = bcd_inc(cur_q.mon);
    end
    if (c_year) begin
      if (cur_q.year >= 8'h99) begin inc.year = 8'h00; c_cent = 1'b1; end
      else                           inc.year = bcd_inc(cur_q.year);
    end
    if (c_cent) begin
      inc.cent = (cur_q.cent >= 8'h39) ? 8'h00 : bcd_inc(cur_q.cent);
    end
  end

  always_comb begin
    cur_d = cur_q;
    if (load_i)               cur_d = load_val_i;
    else if (tick_i && run_i) cur_d = inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= time_t'(reset_bank() & 64'h3FFF_1F3F_073F_7F7F);
    else        cur_q <= cur_d;
  end

  assign cur_o = cur_q;
  assign nxt_o = inc;

  // R4: a running tick always moves the count
  a_r4_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_i && !load_i) |=> (cur_q != $past(cur_q)));
  // R9: stopped counters hold
  a_r9_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cur_q));
  // R7: a load takes the presented value
  a_r7_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cur_q == $past(load_val_i)));
  // R2: legal seconds stay legal while counting
  a_r2_sec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.sec <= 8'h59 && !load_i) |=> (cur_q.sec <= 8'h59));
endmodule

// File: rtl/bcd_ext_bank.sv
`timescale 1ns/1ps
module bcd_ext_bank
  import bcd_clk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          refresh_i,
  input  bank_t         ref_val_i,
  output bank_t         ext_o
);
  bank_t ext_q, ext_d, merged;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_merge
      localparam logic [DW-1:0] FM = field_mask(g);
      assign merged[g] = (ext_q[g] & ~FM) | (ref_val_i[g] & FM);
    end
  endgenerate

  always_comb begin
    ext_d = ext_q;
    if (refresh_i) ext_d = merged;
    if (we_i)      ext_d[addr_i] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= reset_bank();
    else        ext_q <= ext_d;
  end

  assign ext_o = ext_q;

  // R8: a bus write is visible in the addressed register next cycle
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ext_q[$past(addr_i)] == $past(wdata_i)));
  // R10: spare bits never change without a bus write
  a_r10_spare_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ((ext_q[2] & 8'hC0) == ($past(ext_q[2]) & 8'hC0)));
endmodule

// File: rtl/bcd_resume_timer.sv
`timescale 1ns/1ps
module bcd_resume_timer #(
  parameter int MIN_LOW_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic ready_o
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i)           cnt_d = '0;
    else if (cnt_q < LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LIM;
    else        cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == LIM);

  // R6: a held control bit blocks refresh on the following cycle
  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !ready_o);
  // R6: the interval counter never passes its limit
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
endmodule

// File: rtl/bcd_clock_regs.sv
`timescale 1ns/1ps
module bcd_clock_regs
  import bcd_clk_pkg::*;
#(
  parameter int MIN_LOW_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  bank_t ext_bank, load_bank, load_masked;
  time_t cur_time, nxt_time;
  logic  rd_bit, wr_bit, run, load, low_ok, refresh;

  assign rd_bit = ext_bank[IDX_CTRL][6];
  assign wr_bit = ext_bank[IDX_CTRL][7];
  assign run    = ~ext_bank[IDX_SEC][7];
  assign load   = we_i && (addr_i == IDX_CTRL) && wr_bit && !wdata_i[7];

  always_comb begin
    load_bank           = ext_bank;
    load_bank[IDX_CTRL] = {2'b00, wdata_i[5:0]};
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_ldmask
      localparam logic [DW-1:0] FM = field_mask(g);
      assign load_masked[g] = load_bank[g] & FM;
    end
  endgenerate

  assign refresh = tick_i && run && low_ok && !rd_bit && !wr_bit && !load;

  bcd_time_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .run_i      (run),
    .load_i     (load),
    .load_val_i (time_t'(load_masked)),
    .cur_o      (cur_time),
    .nxt_o      (nxt_time)
  );

  bcd_resume_timer #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_resume (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (rd_bit | wr_bit),
    .ready_o (low_ok)
  );

  bcd_ext_bank u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .refresh_i (refresh),
    .ref_val_i (bank_t'(nxt_time)),
    .ext_o     (ext_bank)
  );

  assign rdata_o = ext_bank[addr_i];

  // R5: with the read bit set and no bus write, the external copy is frozen
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bit && !we_i) |=> $stable(ext_bank));
  // R6: a refresh makes the visible seconds match the internal counter
  a_r6_refresh_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !we_i) |=> ((ext_bank[IDX_SEC] & 8'h7F) == cur_time.sec));
endmodule

// File: tb/bcd_clock_regs_tb_top.sv
`timescale 1ns/1ps
module bcd_clock_regs_tb_top;
  localparam int MIN = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int e_clear = -100000;
  logic [7:0] mi [8];
  logic [7:0] me [8];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcd_clock_regs #(.MIN_LOW_CYC(MIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [7:0] fmask(int i);
    case (i)
      0, 1: return 8'h7F;
      2, 4: return 8'h3F;
      3:    return 8'h07;
      5:    return 8'h1F;
      6:    return 8'hFF;
      default: return 8'h3F;
    endcase
  endfunction

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(int i);
    logic [3:0] t, o;
    t = 4'(i / 10);
    o = 4'(i % 10);
    return {t, o};
  endfunction

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_adv();
    int s, mn, h, d, dt, mo, y, c;
    s = b2i(mi[0]); mn = b2i(mi[1]); h = b2i(mi[2]); d = b2i(mi[3]);
    dt = b2i(mi[4]); mo = b2i(mi[5]); y = b2i(mi[6]); c = b2i(mi[7]);
    s++;
    if (s == 60) begin s = 0; mn++; end
    if (mn == 60) begin mn = 0; h++; end
    if (h == 24) begin
      h = 0;
      d = (d == 7) ? 1 : d + 1;
      dt++;
      if (dt > dim(mo, y)) begin dt = 1; mo++; end
      if (mo == 13) begin mo = 1; y++; end
      if (y == 100) begin y = 0; c = (c == 39) ? 0 : c + 1; end
    end
    mi[0] = i2b(s); mi[1] = i2b(mn); mi[2] = i2b(h); mi[3] = i2b(d);
    mi[4] = i2b(dt); mi[5] = i2b(mo); mi[6] = i2b(y); mi[7] = i2b(c);
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check($sformatf("%s reg%0d", tag, i), v, me[i]);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic was_held;
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk);
    #1;
    was_held = me[7][7] | me[7][6];
    if (a == 3'd7 && me[7][7] && !d[7]) begin
      for (int i = 0; i < 7; i++) mi[i] = me[i] & fmask(i);
      mi[7] = d & 8'h3F;
    end
    me[a] = d;
    if (a == 3'd7 && was_held && !d[7] && !d[6]) e_clear = cyc;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    int t;
    @(negedge clk);
    tick_i = 1'b1;
    @(posedge clk);
    #1 t = cyc;
    @(negedge clk);
    tick_i = 1'b0;
    if (!me[0][7]) begin
      model_adv();
      if (!me[7][7] && !me[7][6] && (t - e_clear) > MIN)
        for (int i = 0; i < 8; i++) me[i] = (me[i] & ~fmask(i)) | (mi[i] & fmask(i));
    end
  endtask

  // load a full time through the write-bit sequence
  task automatic set_time(logic [7:0] s, logic [7:0] mn, logic [7:0] h, logic [7:0] d,
                          logic [7:0] dt, logic [7:0] mo, logic [7:0] y, logic [7:0] c);
    wr(3'd7, 8'h80 | c);
    wr(3'd0, s); wr(3'd1, mn); wr(3'd2, h); wr(3'd3, d);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, y);
    wr(3'd7, c);
    idle(MIN + 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, frz;
    void'($urandom(32'h5EED_0BCD));
    me[0] = 8'h80; me[1] = 8'h00; me[2] = 8'h00; me[3] = 8'h01;
    me[4] = 8'h01; me[5] = 8'h01; me[6] = 8'h00; me[7] = 8'h20;
    for (int i = 0; i < 8; i++) mi[i] = me[i] & fmask(i);
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check_all("R1 reset");

    // R9 stopped clock ignores ticks
    do_tick();
    rd(3'd0, v); check("R9 stopped sec", v, 8'h80);
    check_all("R9 stopped");
    wr(3'd0, 8'h00);
    idle(4);
    do_tick();
    rd(3'd0, v); check("R9 running sec", v, 8'h01);

    // R2 / R3 rollovers
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24, 8'h20);
    do_tick();
    rd(3'd4, v); check("R3 leap feb 29", v, 8'h29);
    rd(3'd3, v); check("R2 day 7 to 1", v, 8'h01);
    rd(3'd2, v); check("R2 hour wrap", v, 8'h00);
    check_all("R2 midnight");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
    do_tick();
    rd(3'd5, v); check("R3 non-leap to march", v, 8'h03);
    rd(3'd4, v); check("R3 non-leap date", v, 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23, 8'h20);
    do_tick();
    check_all("R3 april end");
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h20);
    do_tick();
    rd(3'd7, v); check("R3 century carry", v, 8'h21);
    check_all("R3 new year");
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h39);
    do_tick();
    rd(3'd7, v); check("R3 century wrap", v, 8'h00);

    // R5 / R4 / R6 freeze and resume
    set_time(8'h10, 8'h20, 8'h08, 8'h02, 8'h15, 8'h06, 8'h30, 8'h20);
    wr(3'd7, 8'h60);
    for (int k = 0; k < 3; k++) do_tick();
    rd(3'd0, v); check("R5 frozen sec", v, 8'h10);
    check_all("R5 frozen");
    wr(3'd7, 8'h20);
    idle(3);
    do_tick();
    rd(3'd0, v); check("R6 early tick no refresh", v, 8'h10);
    idle(MIN + 4);
    do_tick();
    rd(3'd0, v); check("R4 R6 resumed sec", v, 8'h15);
    check_all("R6 resumed");

    // R7 write-bit load while internal count runs
    wr(3'd7, 8'hA0);
    wr(3'd1, 8'h45);
    do_tick(); do_tick();
    rd(3'd1, v); check("R7 write held in ext", v, 8'h45);
    rd(3'd0, frz);
    wr(3'd7, 8'h20);
    idle(MIN + 4);
    do_tick();
    rd(3'd1, v); check("R7 loaded minutes", v, 8'h45);
    rd(3'd0, v); check("R7 loaded sec plus one", v, frz + 8'h01);

    // R8 plain write reaches ext only
    wr(3'd1, 8'h33);
    rd(3'd1, v); check("R8 write visible", v, 8'h33);
    do_tick();
    rd(3'd1, v); check("R8 replaced on refresh", v, 8'h45);

    // R10 spare bits kept through load and refresh
    set_time(8'h00, 8'h00, 8'hC5, 8'h47, 8'h01, 8'h01, 8'h10, 8'h20);
    do_tick();
    rd(3'd2, v); check("R10 hour spare bits", v, 8'hC5);
    rd(3'd3, v); check("R10 day test bit", v, 8'h47);
    check_all("R10 spare");

    // random loads near boundaries
    for (int it = 0; it < 40; it++) begin
      int y, mo, dt, h, mn, s, d, c, nt;
      y  = int'($urandom % 100);
      mo = 1 + int'($urandom % 12);
      dt = ($urandom % 2) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      mn = ($urandom % 2) ? 59 : int'($urandom % 60);
      s  = 55 + int'($urandom % 5);
      d  = 1 + int'($urandom % 7);
      c  = int'($urandom % 40);
      set_time(i2b(s), i2b(mn), i2b(h), i2b(d), i2b(dt), i2b(mo), i2b(y), i2b(c));
      nt = 1 + int'($urandom % 5);
      for (int k = 0; k < nt; k++) do_tick();
      check_all($sformatf("R2 R3 random %0d", it));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule